// File: doc/BRIEF.md
# Compare-Cleared Timer with Toggle Output

This block is a 16-bit up-counter that advances once per prescaled tick and returns to zero on the tick after it has reached a programmable terminal value. Two writable 16-bit registers can supply that terminal value: a compare register and a capture register. A source select input picks which of the two is used. Each terminal-value hit is a match. A match sets a sticky match flag and, in toggle mode, inverts a waveform output. The output therefore runs at half the match rate, giving a frequency of f_clk / (2·N·(1+TOP)).

The terminal value is not double buffered. A write takes effect at once. If the new value is below the current count, the counter misses the match. It then runs up to 0xFFFF, wraps to zero, and only then matches. A separate sticky overflow flag records every wrap from 0xFFFF to 0x0000. Software clears each flag with a one-cycle strobe. Pin direction control and interrupt routing belong to other blocks.

Top module: `ctc_timer`

## Requirements
- R1: After synchronous reset, `count` is 0, `wave_out` is 0, and both `match_flag` and `ovf_flag` are 0.
- R2: `clk_sel` sets the tick rate:
  - 1 gives one tick every clock cycle.
  - 2, 3, 4 and 5 give one tick every 8, 64, 256 and 1024 cycles.
  - 0, 6 and 7 give no ticks, and `count` holds its value.
- R3: On a tick where `count` differs from TOP, `count` rises by one, wrapping from 0xFFFF to 0. On a tick where `count` equals TOP, `count` becomes 0 on the next cycle.
- R4: When `top_src` is 0, TOP is the compare register. When `top_src` is 1, TOP is the capture register, and the compare register then has no effect on the count.
- R5: A register write is visible to the comparison on the cycle after the write strobe. If the new TOP is below the current count, no match occurs until the counter has passed 0xFFFF and wrapped. The match then follows TOP+1 ticks after the wrap.
- R6: With `out_mode` = 1, `wave_out` inverts on every match. Its level therefore changes every N·(TOP+1) clock cycles in steady state.
- R7: With `out_mode` = 0, 2 or 3, `wave_out` keeps its value across matches.
- R8: `match_flag` becomes 1 on the cycle after a match tick. It then stays 1 until it is cleared.
- R9: `ovf_flag` becomes 1 on the cycle after a tick on which `count` was 0xFFFF. It then stays 1 until it is cleared.
- R10: A one-cycle `match_clr` or `ovf_clr` strobe clears its flag. If a set event occurs in the same cycle as the strobe, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Prescaler select (0 stops the counter) |
| top_src | input | 1 | TOP source: 0 compare register, 1 capture register |
| out_mode | input | 2 | Waveform action on match: 1 toggles, other values hold |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write data |
| cap_we | input | 1 | Capture register write strobe |
| cap_wdata | input | 16 | Capture register write data |
| match_clr | input | 1 | Match flag clear strobe |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| count | output | 16 | Current counter value |
| wave_out | output | 1 | Toggle waveform output |
| match_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions check the following on every cycle:
- the counter steps by one or clears at TOP;
- the count holds between ticks and while the prescaler is stopped;
- the waveform inverts or holds according to the mode on each match;
- the flags set and clear, with a set winning over a coincident clear.

Some behaviour only the bench scenarios can show. These are the exact tick spacing of each prescaler factor and the choice of compare or capture register as TOP. Also included are the missed match after lowering TOP below the count, which needs a full 65,536-tick excursion, and the sticky hold of a flag over many idle cycles.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    localparam int CTC_CNT_W = 16;
    localparam int CTC_PRE_W = 10;

    typedef enum logic [2:0] {
        CLK_OFF     = 3'd0,
        CLK_DIV1    = 3'd1,
        CLK_DIV8    = 3'd2,
        CLK_DIV64   = 3'd3,
        CLK_DIV256  = 3'd4,
        CLK_DIV1024 = 3'd5
    } clk_sel_e;

    typedef enum logic {
        SRC_CMP = 1'b0,
        SRC_CAP = 1'b1
    } top_src_e;

    localparam logic [1:0] OUT_TOGGLE = 2'd1;

    typedef struct packed {
        logic       en;
        logic [3:0] shift;
    } div_cfg_t;

    typedef struct packed {
        logic match;
        logic wrap;
    } cnt_evt_t;

    function automatic div_cfg_t div_cfg(input logic [2:0] sel);
        div_cfg_t c;
        unique case (sel)
            CLK_DIV1:    c = '{en: 1'b1, shift: 4'd0};
            CLK_DIV8:    c = '{en: 1'b1, shift: 4'd3};
            CLK_DIV64:   c = '{en: 1'b1, shift: 4'd6};
            CLK_DIV256:  c = '{en: 1'b1, shift: 4'd8};
            CLK_DIV1024: c = '{en: 1'b1, shift: 4'd10};
            default:     c = '{en: 1'b0, shift: 4'd0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ctc_prescaler.sv
module ctc_prescaler
    import ctc_pkg::*;
#(
    parameter int PRE_W = CTC_PRE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] clk_sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;
    div_cfg_t         cfg;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        cfg  = div_cfg(clk_sel);
        span = (PRE_W+1)'(1) << cfg.shift;
        mask = span[PRE_W-1:0] - 1'b1;
        tick = cfg.en && ((pre_q & mask) == mask);
    end

endmodule

// File: rtl/ctc_counter.sv
module ctc_counter
    import ctc_pkg::*;
#(
    parameter int CNT_W = CTC_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] count,
    output cnt_evt_t         evt
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        evt.match = tick && (cnt_q == top_val);
        evt.wrap  = tick && (&cnt_q);
        cnt_d     = cnt_q;
        if (evt.match)  cnt_d = '0;
        else if (tick)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/ctc_wave.sv
module ctc_wave
    import ctc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_evt_t evt,
    input  logic [1:0] out_mode,
    input  logic     match_clr,
    input  logic     ovf_clr,
    output logic     wave_out,
    output logic     match_flag,
    output logic     ovf_flag
);

    logic wave_q, mflag_q, oflag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q  <= 1'b0;
            mflag_q <= 1'b0;
            oflag_q <= 1'b0;
        end else begin
            if (evt.match && out_mode == OUT_TOGGLE) wave_q <= ~wave_q;
            mflag_q <= evt.match | (mflag_q & ~match_clr);
            oflag_q <= evt.wrap  | (oflag_q & ~ovf_clr);
        end
    end

    assign wave_out   = wave_q;
    assign match_flag = mflag_q;
    assign ovf_flag   = oflag_q;

endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
    import ctc_pkg::*;
#(
    parameter int CNT_W = CTC_CNT_W,
    parameter int PRE_W = CTC_PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       clk_sel,
    input  logic             top_src,
    input  logic [1:0]       out_mode,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cap_we,
    input  logic [CNT_W-1:0] cap_wdata,
    input  logic             match_clr,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             wave_out,
    output logic             match_flag,
    output logic             ovf_flag
);

    logic [CNT_W-1:0] cmp_q, cap_q, top_s;
    logic             tick_s;
    cnt_evt_t         evt_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            cap_q <= '0;
        end else begin
            if (cmp_we) cmp_q <= cmp_wdata;
            if (cap_we) cap_q <= cap_wdata;
        end
    end

    assign top_s = (top_src_e'(top_src) == SRC_CAP) ? cap_q : cmp_q;

    ctc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clk_sel (clk_sel),
        .tick    (tick_s)
    );

    ctc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_s),
        .top_val (top_s),
        .count   (count),
        .evt     (evt_s)
    );

    ctc_wave u_wave (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt_s),
        .out_mode   (out_mode),
        .match_clr  (match_clr),
        .ovf_clr    (ovf_clr),
        .wave_out   (wave_out),
        .match_flag (match_flag),
        .ovf_flag   (ovf_flag)
    );

endmodule

// File: rtl/ctc_timer_chk.sv
module ctc_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [2:0]       clk_sel,
    input logic [CNT_W-1:0] top_val,
    input logic [CNT_W-1:0] count,
    input logic [1:0]       out_mode,
    input logic             wave_out,
    input logic             match_flag,
    input logic             ovf_flag,
    input logic             match_clr,
    input logic             ovf_clr
);

    logic             at_top, at_max;
    logic [CNT_W-1:0] cnt_inc;

    assign at_top  = tick && (count == top_val);
    assign at_max  = tick && (&count);
    assign cnt_inc = count + 1'b1;

    a_r3_clear_at_top: assert property (@(posedge clk) disable iff (rst)
        at_top |=> count == '0);

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (tick && count != top_val) |=> count == $past(cnt_inc));

    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    a_r2_stopped: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 3'd0 || clk_sel > 3'd5) |-> !tick);

    a_r6_toggle: assert property (@(posedge clk) disable iff (rst)
        (at_top && out_mode == 2'd1) |=> wave_out != $past(wave_out));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !(at_top && out_mode == 2'd1) |=> $stable(wave_out));

    a_r8_match_set: assert property (@(posedge clk) disable iff (rst)
        at_top |=> match_flag);

    a_r9_ovf_set: assert property (@(posedge clk) disable iff (rst)
        at_max |=> ovf_flag);

    a_r10_match_clear: assert property (@(posedge clk) disable iff (rst)
        (match_clr && !at_top) |=> !match_flag);

    a_r10_ovf_clear: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !at_max) |=> !ovf_flag);

endmodule

bind ctc_timer ctc_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_s),
    .clk_sel    (clk_sel),
    .top_val    (top_s),
    .count      (count),
    .out_mode   (out_mode),
    .wave_out   (wave_out),
    .match_flag (match_flag),
    .ovf_flag   (ovf_flag),
    .match_clr  (match_clr),
    .ovf_clr    (ovf_clr)
);

// File: tb/ctc_timer_tb.sv
module ctc_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  clk_sel = '0;
    logic        top_src = 1'b0;
    logic [1:0]  out_mode = '0;
    logic        cmp_we = 1'b0, cap_we = 1'b0;
    logic [15:0] cmp_wdata = '0, cap_wdata = '0;
    logic        match_clr = 1'b0, ovf_clr = 1'b0;
    logic [15:0] count;
    logic        wave_out, match_flag, ovf_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ctc_timer dut_i (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .top_src(top_src),
        .out_mode(out_mode), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .cap_we(cap_we), .cap_wdata(cap_wdata), .match_clr(match_clr),
        .ovf_clr(ovf_clr), .count(count), .wave_out(wave_out),
        .match_flag(match_flag), .ovf_flag(ovf_flag)
    );

    // sel, src, cmp, cap, expected half period in clock cycles = N*(TOP+1)
    localparam int NV = 7;
    localparam int V_SEL [NV] = '{1, 1, 2, 3, 4, 5, 1};
    localparam int V_SRC [NV] = '{0, 0, 0, 1, 0, 1, 1};
    localparam int V_CMP [NV] = '{0, 5, 3, 100, 1, 9, 32};
    localparam int V_CAP [NV] = '{9, 0, 0, 2, 50, 9, 7};
    localparam int V_HALF[NV] = '{1, 6, 32, 192, 512, 10240, 8};

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; clk_sel = '0; top_src = 1'b0; out_mode = '0;
        cmp_we = 1'b0; cap_we = 1'b0; match_clr = 1'b0; ovf_clr = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic wr_cmp(input int v);
        cmp_we = 1'b1; cmp_wdata = 16'(v); cyc(1); cmp_we = 1'b0;
    endtask

    task automatic wr_cap(input int v);
        cap_we = 1'b1; cap_wdata = 16'(v); cyc(1); cap_we = 1'b0;
    endtask

    task automatic wait_toggle(output int n, input int limit);
        logic w0;
        w0 = wave_out;
        n = 0;
        do begin
            cyc(1);
            n++;
        end while (wave_out == w0 && n < limit);
    endtask

    initial begin
        int n, c;
        bit seen_match;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check(count == 0, "R1", "count after reset", count, 0);
        check(wave_out == 0, "R1", "wave after reset", wave_out, 0);
        check(match_flag == 0 && ovf_flag == 0, "R1", "flags after reset",
              {match_flag, ovf_flag}, 0);

        // Table: R2 prescale, R4 TOP source, R6 toggle period
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr_cmp(V_CMP[i]);
            wr_cap(V_CAP[i]);
            top_src  = V_SRC[i][0];
            out_mode = 2'd1;
            clk_sel  = 3'(V_SEL[i]);
            wait_toggle(n, 20000);
            wait_toggle(n, 20000);
            check(n == V_HALF[i], "R6", $sformatf("R2 R4 half period vector %0d", i),
                  n, V_HALF[i]);
        end

        // R2 / R3: divide by 8, count advances 10 in 80 cycles
        do_reset();
        wr_cmp(1000);
        clk_sel = 3'd2;
        cyc(5);
        c = count;
        cyc(80);
        check(count == c + 10, "R3", "R2 count step at N=8", count, c + 10);

        // R2: stopped counter holds (select 0 and 6)
        clk_sel = 3'd0; cyc(2); c = count; cyc(50);
        check(count == c, "R2", "count held with select 0", count, c);
        clk_sel = 3'd6; cyc(50);
        check(count == c, "R2", "count held with select 6", count, c);

        // R7: hold modes leave wave unchanged while matches occur (R8 sticky)
        do_reset();
        wr_cmp(0);
        out_mode = 2'd0; clk_sel = 3'd1; cyc(20);
        check(wave_out == 0, "R7", "wave with mode 0", wave_out, 0);
        out_mode = 2'd2; cyc(20);
        check(wave_out == 0, "R7", "wave with mode 2", wave_out, 0);
        check(match_flag == 1, "R8", "match flag set", match_flag, 1);

        // R10: set wins over a coincident clear
        match_clr = 1'b1; cyc(1);
        check(match_flag == 1, "R10", "flag with clear and match together", match_flag, 1);
        clk_sel = 3'd0; cyc(1);
        match_clr = 1'b0; cyc(1);
        check(match_flag == 0, "R10", "match flag cleared", match_flag, 0);

        // R5: lower TOP below count -> miss, wrap, then match
        do_reset();
        wr_cmp(200);
        out_mode = 2'd1; clk_sel = 3'd1;
        while (count < 150) cyc(1);
        wr_cmp(50);
        seen_match = 0;
        n = 0;
        while (!ovf_flag && n < 70000) begin
            cyc(1);
            n++;
            if (match_flag) seen_match = 1;
        end
        check(ovf_flag == 1, "R9", "overflow after missed match", ovf_flag, 1);
        check(seen_match == 0, "R5", "no match before wrap", seen_match, 0);
        check(count == 0, "R9", "count at overflow", count, 0);
        n = 0;
        do begin cyc(1); n++; end while (!match_flag && n < 1000);
        check(n == 51, "R5", "cycles from wrap to match", n, 51);
        check(count == 0, "R3", "count cleared at match", count, 0);

        // R9 sticky, R10 overflow clear
        cyc(100);
        check(ovf_flag == 1, "R9", "overflow flag sticky", ovf_flag, 1);
        ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
        check(ovf_flag == 0, "R10", "overflow flag cleared", ovf_flag, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule